// File: doc/BRIEF.md
# Serial Bus Clock and Strobe Generator

This block produces every timing signal of a terminal-side serial time-division bus from a single 7.68 MHz reference clock. It produces a 768 kHz bit clock (reference divided by 10) and a 1.536 MHz data clock running at twice the bit rate (reference divided by 5). It also produces an 8 kHz frame sync and a strobe that can be set to mark one timeslot, the D-channel bit pair, or both. Each frame lasts 960 reference cycles and holds 96 bit periods, grouped as 12 timeslots of 8 bits. The block also exposes the current bit index and timeslot index, so that neighbouring logic can place data in the right positions. A copy of the reference clock is passed straight out for other devices. That copy runs free and is not locked to the line.

The core is a phase sequencer with eleven named states. PH_HOLD is the reset state. PH_0 through PH_9 are the ten reference cycles of one bit period. The sequencer has three transitions: PH_HOLD goes to PH_0 on the first clock edge after reset is released, each PH_n goes to PH_n+1, and PH_9 wraps to PH_0. Leaving PH_9 advances the bit and timeslot counters. The clocks, the frame sync and the strobe are all decoded from the sequencer state and the counters.

Top module: `sbclk_top`

## Requirements
- R1: While reset is low, fsc, dcl, bcl and strobe are 0 and bit_idx and slot_idx are 0. The first rising reference edge after reset is released starts bit 0 of timeslot 0, with fsc, bcl and dcl all high.
- R2: bcl has a period of 10 reference cycles. It is high for the first 5 cycles of each bit period and low for the last 5.
- R3: dcl has a period of 5 reference cycles. It is high for the first 3 cycles of each half bit period and low for the other 2.
- R4: bit_idx steps by one at each rising edge of bcl and wraps from 7 to 0. slot_idx steps by one when bit_idx wraps, and wraps from 11 to 0.
- R5: fsc is high for exactly 5 reference cycles starting at the first cycle of bit 0 of timeslot 0. It repeats every 960 reference cycles.
- R6: With cfg_slot_en = 1, strobe is high for all 80 reference cycles of the timeslot whose index equals cfg_slot.
- R7: With cfg_dch_en = 1, strobe is high during bits 0 and 1 of timeslot 3, which is 20 reference cycles per frame.
- R8: The two strobe sources are ORed together. A cfg_slot value of 12 or more selects no timeslot, and the same holds when cfg_slot_en = 0.
- R9: ref_out follows clk_ref at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 7.68 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slot | input | 4 | Timeslot marked by the strobe |
| cfg_slot_en | input | 1 | Enables the timeslot strobe |
| cfg_dch_en | input | 1 | Enables the D-channel bit-pair strobe |
| ref_out | output | 1 | Buffered copy of the reference clock |
| fsc | output | 1 | 8 kHz frame sync |
| dcl | output | 1 | 1.536 MHz data clock |
| bcl | output | 1 | 768 kHz bit clock |
| strobe | output | 1 | Programmable timeslot / D-channel strobe |
| bit_idx | output | 3 | Bit position within the timeslot |
| slot_idx | output | 4 | Timeslot index within the frame |

## Verification
The strobe edge check assumes that the strobe configuration changes only in a cycle where the assertion excuses it. Under that assumption, every rise of the strobe comes from the bit counter and lines up with a rising bit clock. The bench therefore changes the configuration only between frames and then waits for the next frame-sync rise before it measures anything. Reset is applied both at the start and in the middle of a frame. It is released on the falling reference edge, so the first running cycle is always well defined.

// File: rtl/sbclk_pkg.sv
package sbclk_pkg;
    localparam int BITS_PER_SLOT = 8;
    localparam int SLOTS         = 12;
    localparam int DCH_SLOT      = 3;
    localparam int DCH_BITS      = 2;
    localparam int BIT_W         = $clog2(BITS_PER_SLOT);
    localparam int SLOT_W        = $clog2(SLOTS);

    typedef enum logic [3:0] {
        PH_HOLD, PH_0, PH_1, PH_2, PH_3, PH_4,
        PH_5, PH_6, PH_7, PH_8, PH_9
    } phase_e;
endpackage

// File: rtl/sbclk_phase_fsm.sv
module sbclk_phase_fsm
    import sbclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase,
    output logic   run,
    output logic   bcl,
    output logic   dcl,
    output logic   adv
);
    phase_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_HOLD;
        else        state <= nxt;
    end

    always_comb begin
        nxt = PH_HOLD;
        unique case (state)
            PH_HOLD: nxt = PH_0;
            PH_0:    nxt = PH_1;
            PH_1:    nxt = PH_2;
            PH_2:    nxt = PH_3;
            PH_3:    nxt = PH_4;
            PH_4:    nxt = PH_5;
            PH_5:    nxt = PH_6;
            PH_6:    nxt = PH_7;
            PH_7:    nxt = PH_8;
            PH_8:    nxt = PH_9;
            PH_9:    nxt = PH_0;
            default: nxt = PH_HOLD;
        endcase
    end

    always_comb begin
        run = 1'b1;
        bcl = 1'b0;
        dcl = 1'b0;
        adv = 1'b0;
        unique case (state)
            PH_HOLD: run = 1'b0;
            PH_0, PH_1, PH_2: begin bcl = 1'b1; dcl = 1'b1; end
            PH_3, PH_4:       bcl = 1'b1;
            PH_5, PH_6, PH_7: dcl = 1'b1;
            PH_8:             ;
            PH_9:             adv = 1'b1;
            default:          run = 1'b0;
        endcase
    end

    assign phase = state;

    // R2
    bcl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bcl) |-> (state == PH_0));
    // R3
    dcl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dcl) |-> (state == PH_0 || state == PH_5));
endmodule

// File: rtl/sbclk_frame_cnt.sv
module sbclk_frame_cnt #(
    parameter int BPS   = 8,
    parameter int NSLOT = 12,
    localparam int BW   = $clog2(BPS),
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [BW-1:0] bit_q,
    output logic [SW-1:0] slot_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            slot_q <= '0;
        end else if (adv) begin
            if (bit_q == BW'(BPS - 1)) begin
                bit_q  <= '0;
                slot_q <= (slot_q == SW'(NSLOT - 1)) ? '0 : slot_q + 1'b1;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // R4
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(adv) |-> $stable({slot_q, bit_q}));
    // R4
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q < SW'(NSLOT));
endmodule

// File: rtl/sbclk_strobe_dec.sv
module sbclk_strobe_dec
    import sbclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [BIT_W-1:0]  bit_q,
    input  logic [SLOT_W-1:0] slot_q,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic              cfg_slot_en,
    input  logic              cfg_dch_en,
    output logic              strobe
);
    logic hit_slot, hit_dch;

    always_comb begin
        hit_slot = cfg_slot_en && (slot_q == cfg_slot);
        hit_dch  = cfg_dch_en && (slot_q == SLOT_W'(DCH_SLOT))
                   && (bit_q < BIT_W'(DCH_BITS));
        strobe   = run && (hit_slot || hit_dch);
    end

    // R8
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dch_en && cfg_slot >= SLOT_W'(SLOTS)) |-> !strobe);
    // R7
    dch_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !cfg_slot_en) |-> (slot_q == SLOT_W'(DCH_SLOT)));
endmodule

// File: rtl/sbclk_top.sv
module sbclk_top
    import sbclk_pkg::*;
(
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic              cfg_slot_en,
    input  logic              cfg_dch_en,
    output logic              ref_out,
    output logic              fsc,
    output logic              dcl,
    output logic              bcl,
    output logic              strobe,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [SLOT_W-1:0] slot_idx
);
    phase_e phase;
    logic   run, adv;

    sbclk_phase_fsm u_fsm (
        .clk(clk_ref), .rst_n(rst_n), .phase(phase), .run(run),
        .bcl(bcl), .dcl(dcl), .adv(adv)
    );

    sbclk_frame_cnt #(.BPS(BITS_PER_SLOT), .NSLOT(SLOTS)) u_cnt (
        .clk(clk_ref), .rst_n(rst_n), .adv(adv),
        .bit_q(bit_idx), .slot_q(slot_idx)
    );

    sbclk_strobe_dec u_stb (
        .clk(clk_ref), .rst_n(rst_n), .run(run), .bit_q(bit_idx),
        .slot_q(slot_idx), .cfg_slot(cfg_slot), .cfg_slot_en(cfg_slot_en),
        .cfg_dch_en(cfg_dch_en), .strobe(strobe)
    );

    assign ref_out = clk_ref;
    assign fsc     = bcl && (bit_idx == '0) && (slot_idx == '0);

    // R5
    fsc_pos_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(fsc) |-> ($rose(bcl) && phase == PH_0));
    // R6
    strobe_edge_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($rose(strobe) && $stable({cfg_slot, cfg_slot_en, cfg_dch_en}))
        |-> $rose(bcl));
endmodule

// File: tb/tb_sbclk_top.sv
`timescale 1ns/1ps
module tb_sbclk_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_slot = '0;
    logic       cfg_slot_en = 1'b0;
    logic       cfg_dch_en = 1'b0;
    logic       ref_out, fsc, dcl, bcl, strobe;
    logic [2:0] bit_idx;
    logic [3:0] slot_idx;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sbclk_top dut (
        .clk_ref(clk), .rst_n(rst_n), .cfg_slot(cfg_slot),
        .cfg_slot_en(cfg_slot_en), .cfg_dch_en(cfg_dch_en),
        .ref_out(ref_out), .fsc(fsc), .dcl(dcl), .bcl(bcl),
        .strobe(strobe), .bit_idx(bit_idx), .slot_idx(slot_idx)
    );

    localparam int NV = 9;
    localparam int V_SLOT [NV] = '{0, 5, 11, 2, 7, 3, 13, 0, 15};
    localparam int V_SEN  [NV] = '{1, 1, 1, 0, 1, 1, 1, 0, 1};
    localparam int V_DEN  [NV] = '{0, 0, 0, 1, 1, 1, 0, 0, 1};
    localparam int V_CNT  [NV] = '{80, 80, 80, 20, 100, 80, 0, 0, 20};
    localparam int V_FIRST[NV] = '{0, 400, 880, 240, 240, 240, -1, -1, 240};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        check({fsc, dcl, bcl, strobe} == 4'b0, tag, {fsc, dcl, bcl, strobe}, 0);
        check(bit_idx == 0 && slot_idx == 0, tag, {slot_idx, bit_idx}, 0);
    endtask

    task automatic run_frame(input int v);
        int  guard = 0;
        logic prev;
        int  cnt = 0, first = -1;
        int  bad_clk = 0, bad_idx = 0, bad_fsc = 0, bad_stb = 0;
        do begin
            prev = fsc;
            @(negedge clk);
            guard++;
        end while (!(fsc && !prev) && guard < 2000);
        for (int i = 0; i < 960; i++) begin
            bit e_bcl = (i % 10) < 5;
            bit e_dcl = (i % 5) < 3;
            bit e_fsc = i < 5;
            int e_bit = (i / 10) % 8;
            int e_slot = i / 80;
            bit e_stb = (V_SEN[v] == 1 && e_slot == V_SLOT[v]) ||
                        (V_DEN[v] == 1 && e_slot == 3 && e_bit < 2);
            if (bcl != e_bcl || dcl != e_dcl) bad_clk++;
            if (bit_idx != e_bit[2:0] || slot_idx != e_slot[3:0]) bad_idx++;
            if (fsc != e_fsc) bad_fsc++;
            if (strobe != e_stb) bad_stb++;
            if (strobe) begin
                cnt++;
                if (first < 0) first = i;
            end
            @(negedge clk);
        end
        // R2 / R3 clock waveforms over a frame
        check(bad_clk == 0, "R2_R3 bcl/dcl shape", bad_clk, 0);
        // R4 counter sequence
        check(bad_idx == 0, "R4 bit/slot sequence", bad_idx, 0);
        // R5 frame sync width and period
        check(bad_fsc == 0 && fsc == 1'b1, "R5 fsc window/period", bad_fsc, 0);
        // R6 R7 R8 strobe per cycle, count and first position
        check(bad_stb == 0, "R6_R7_R8 strobe cycles", bad_stb, 0);
        check(cnt == V_CNT[v], "R6_R7_R8 strobe count", cnt, V_CNT[v]);
        check(first == V_FIRST[v], "R6_R7_R8 strobe first", first, V_FIRST[v]);
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R1 first running cycle is bit 0 of slot 0
        check(fsc && bcl && dcl, "R1 first cycle", {fsc, bcl, dcl}, 7);
        check(bit_idx == 0 && slot_idx == 0, "R1 first index", {slot_idx, bit_idx}, 0);
        // R9 reference copy
        check(ref_out == clk, "R9 ref low", ref_out, clk);
        @(posedge clk); #1;
        check(ref_out == 1'b1, "R9 ref high", ref_out, 1);
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            cfg_slot    = V_SLOT[v][3:0];
            cfg_slot_en = V_SEN[v][0];
            cfg_dch_en  = V_DEN[v][0];
            run_frame(v);
        end

        // R1 reset in mid frame
        repeat (337) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_idle("R1 mid-frame reset");
        @(negedge clk);
        check_idle("R1 held reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(fsc && bcl, "R1 restart", {fsc, bcl}, 3);
        // R4 wrap continues after restart
        repeat (80) @(negedge clk);
        check(slot_idx == 1 && bit_idx == 0, "R4 slot step", {slot_idx, bit_idx}, 8);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule